// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block copies a run of data units from one memory region to another on its own, once software has set it up. Software programs a source address, a destination address and a unit count through a small write/read register port, picks a unit width of one, two or four bytes and an address-stepping mode for each side, and then sets the enable bit. The engine then moves one unit at a time. It reads the unit from the source over a request/ready memory master port, writes it to the destination, steps both addresses and lowers the count.

When the count runs out, the engine sets an end flag and raises its interrupt if software allowed it. A global register carries a master enable and two sticky error flags. One flag records a misaligned address and the other records an external non-maskable event. Either flag holds the channel still until software writes it back to zero.

Software can halt the channel between units by clearing the enable bit. A separate clear command abandons a unit that is still in flight. While a transfer runs, software may read back the addresses and the remaining count to see how far the transfer has got.

Top module: `mdma_channel`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and `irq` is low. The register offsets are: 0 source address, 1 destination address, 2 unit count, 3 channel control, 4 global, 5 channel clear (write only).
- R2: Each unit is moved as one read at the source address, then one write at the destination address. The write carries the read data masked to the unit width, right-aligned on the data bus.
- R3: The unit size index is {control bit 20, control bit 3}. Index 0 selects 1 byte, 1 selects 2 bytes, 2 selects 4 bytes, and 3 falls back to 1 byte. `mem_size` shows the log2 of the selected size.
- R4: Control bits [15:14] set the source stepping and bits [13:12] set the destination stepping. 01 increments, 10 decrements, and 00 or 11 holds the address fixed. Each step equals the unit size in bytes.
- R5: The count register is 24 bits wide, counts units and drops by one per completed unit. After N units it reads zero, and each incrementing address reads its start value plus N times the unit size.
- R6: After the last unit's write completes, the end flag (control bit 1) is set and no further access is issued. `irq` equals interrupt-enable (control bit 2) AND the end flag.
- R7: Enabling the channel with a count of zero sets the end flag without issuing any access.
- R8: Units start only when all of these hold: enable (control bit 0) is 1, the end flag is 0, auto-request (control bit 10) is 1, master enable (global bit 0) is 1, and both the event flag (global bit 1) and the error flag (global bit 2) are 0.
- R9: While the channel is busy (enable 1 and end flag 0) or a unit is in flight, writes to the source, destination and count registers are ignored, and so is the size field of a control write.
- R10: If a unit would start with a source or destination address that is not aligned to the unit size, the error flag is set and no access is issued. The enable bit stays 1 and the end flag stays 0.
- R11: A pulse on `nmi_in` sets the event flag. Both global flags are sticky and clear only when software writes 0 to their bit. A unit already in flight finishes before the channel stops, and the transfer resumes once the flags are cleared.
- R12: Clearing the enable bit stops the channel before its next unit but lets an in-flight access wait for `ready`. A write to the clear register drops `mem_req` in the next cycle and leaves the count and addresses as they were.
- R13: Once `mem_req` is high, it stays high with stable `mem_addr` and `mem_we` until `mem_ready` is seen, unless a clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| nmi_in | input | 1 | External non-maskable event pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Log2 of the access width in bytes |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ready | input | 1 | Completes the pending access |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The bench targets four corner cases:
- **Size fallback.** Index 3 must fall back to single bytes. A design that indexed past its table would step by a wrong amount and the address sequence would go wrong at once.
- **Protection window.** A design that let address or count writes land during a busy transfer would later issue accesses at the written garbage address.
- **Flag handling.** For the error and event flags, the bench checks that a unit in flight completes, that the partial count is correct, and that the transfer resumes after the flags clear. A design that dropped the in-flight access, or failed to stop, would produce a different access count.
- **Halt versus clear.** The bench separates halting, which keeps the pending request up, from clearing, which drops it. It also checks that a zero count ends at once without touching memory.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;
  localparam logic [2:0] A_SRC = 3'd0;
  localparam logic [2:0] A_DST = 3'd1;
  localparam logic [2:0] A_CNT = 3'd2;
  localparam logic [2:0] A_CTL = 3'd3;
  localparam logic [2:0] A_GLB = 3'd4;
  localparam logic [2:0] A_CLR = 3'd5;

  localparam int C_EN    = 0;
  localparam int C_END   = 1;
  localparam int C_IE    = 2;
  localparam int C_SZLO  = 3;
  localparam int C_AUTO  = 10;
  localparam int C_DMODE = 12;
  localparam int C_SMODE = 14;
  localparam int C_SZHI  = 20;

  localparam int G_ME  = 0;
  localparam int G_NMI = 1;
  localparam int G_AE  = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mv_state_e;

  // size index -> log2 bytes; out-of-range index falls back to entry 0
  function automatic logic [1:0] unit_lg(input logic [1:0] idx);
    case (idx)
      2'd1:    unit_lg = 2'd1;
      2'd2:    unit_lg = 2'd2;
      default: unit_lg = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mdma_rst_sync.sv
`timescale 1ns/1ps
module mdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/mdma_regs.sv
`timescale 1ns/1ps
module mdma_regs
  import mdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          nmi_in,
  input  logic          upd,
  input  logic [AW-1:0] src_nxt,
  input  logic [AW-1:0] dst_nxt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          te_set,
  input  logic          ae_set,
  input  logic          mv_idle,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          en_q,
  output logic          te_q,
  output logic          ie_q,
  output logic          auto_q,
  output logic [1:0]    lg,
  output logic [1:0]    smode_q,
  output logic [1:0]    dmode_q,
  output logic          me_q,
  output logic          nmi_q,
  output logic          ae_q,
  output logic          clr_pulse
);
  logic [AW-1:0] src_d, dst_d;
  logic [CW-1:0] cnt_d;
  logic en_d, te_d, ie_d, auto_d, me_d, nmi_d, ae_d;
  logic [1:0] sz_q, sz_d, smode_d, dmode_d;
  logic w_src, w_dst, w_cnt, w_ctl, w_glb, open_win;
  logic unused_wbits;

  assign w_src     = reg_wr && (reg_addr == A_SRC);
  assign w_dst     = reg_wr && (reg_addr == A_DST);
  assign w_cnt     = reg_wr && (reg_addr == A_CNT);
  assign w_ctl     = reg_wr && (reg_addr == A_CTL);
  assign w_glb     = reg_wr && (reg_addr == A_GLB);
  assign clr_pulse = reg_wr && (reg_addr == A_CLR);
  assign open_win  = !(en_q && !te_q) && mv_idle;
  assign lg        = unit_lg(sz_q);
  assign unused_wbits = ^reg_wdata;

  always_comb begin
    src_d = src_q; dst_d = dst_q; cnt_d = cnt_q;
    en_d = en_q; te_d = te_q; ie_d = ie_q; auto_d = auto_q;
    sz_d = sz_q; smode_d = smode_q; dmode_d = dmode_q;
    me_d = me_q; nmi_d = nmi_q; ae_d = ae_q;
    if (upd) begin
      src_d = src_nxt; dst_d = dst_nxt; cnt_d = cnt_nxt;
    end else if (open_win) begin
      if (w_src) src_d = reg_wdata[AW-1:0];
      if (w_dst) dst_d = reg_wdata[AW-1:0];
      if (w_cnt) cnt_d = reg_wdata[CW-1:0];
    end
    if (w_ctl) begin
      en_d    = reg_wdata[C_EN];
      te_d    = reg_wdata[C_END];
      ie_d    = reg_wdata[C_IE];
      auto_d  = reg_wdata[C_AUTO];
      smode_d = reg_wdata[C_SMODE +: 2];
      dmode_d = reg_wdata[C_DMODE +: 2];
      if (open_win) sz_d = {reg_wdata[C_SZHI], reg_wdata[C_SZLO]};
    end
    if (te_set) te_d = 1'b1;
    if (w_glb) begin
      me_d  = reg_wdata[G_ME];
      nmi_d = nmi_q & reg_wdata[G_NMI];
      ae_d  = ae_q & reg_wdata[G_AE];
    end
    if (nmi_in) nmi_d = 1'b1;
    if (ae_set) ae_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; te_q <= 1'b0; ie_q <= 1'b0; auto_q <= 1'b0;
      sz_q <= '0; smode_q <= '0; dmode_q <= '0;
      me_q <= 1'b0; nmi_q <= 1'b0; ae_q <= 1'b0;
    end else begin
      src_q <= src_d; dst_q <= dst_d; cnt_q <= cnt_d;
      en_q <= en_d; te_q <= te_d; ie_q <= ie_d; auto_q <= auto_d;
      sz_q <= sz_d; smode_q <= smode_d; dmode_q <= dmode_d;
      me_q <= me_d; nmi_q <= nmi_d; ae_q <= ae_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SRC: reg_rdata[AW-1:0] = src_q;
      A_DST: reg_rdata[AW-1:0] = dst_q;
      A_CNT: reg_rdata[CW-1:0] = cnt_q;
      A_CTL: begin
        reg_rdata[C_EN]        = en_q;
        reg_rdata[C_END]       = te_q;
        reg_rdata[C_IE]        = ie_q;
        reg_rdata[C_SZLO]      = sz_q[0];
        reg_rdata[C_SZHI]      = sz_q[1];
        reg_rdata[C_AUTO]      = auto_q;
        reg_rdata[C_SMODE +: 2] = smode_q;
        reg_rdata[C_DMODE +: 2] = dmode_q;
      end
      A_GLB: begin
        reg_rdata[G_ME]  = me_q;
        reg_rdata[G_NMI] = nmi_q;
        reg_rdata[G_AE]  = ae_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdma_mover.sv
`timescale 1ns/1ps
module mdma_mover
  import mdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [AW-1:0] src_q,
  input  logic [AW-1:0] dst_q,
  input  logic [CW-1:0] cnt_q,
  input  logic [1:0]    lg,
  input  logic [1:0]    smode,
  input  logic [1:0]    dmode,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          upd,
  output logic [AW-1:0] src_nxt,
  output logic [AW-1:0] dst_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          te_set,
  output logic          ae_set,
  output logic          idle
);
  mv_state_e st_q, st_d;
  logic [DW-1:0] buf_q, buf_d, dmask;
  logic [AW-1:0] step;
  logic misalign;

  assign step     = AW'(1) << lg;
  assign misalign = |(src_q & (step - AW'(1))) || |(dst_q & (step - AW'(1)));
  assign cnt_nxt  = cnt_q - CW'(1);

  always_comb begin
    case (lg)
      2'd0:    dmask = DW'(8'hFF);
      2'd1:    dmask = DW'(16'hFFFF);
      default: dmask = '1;
    endcase
    case (smode)
      2'b01:   src_nxt = src_q + step;
      2'b10:   src_nxt = src_q - step;
      default: src_nxt = src_q;
    endcase
    case (dmode)
      2'b01:   dst_nxt = dst_q + step;
      2'b10:   dst_nxt = dst_q - step;
      default: dst_nxt = dst_q;
    endcase
  end

  always_comb begin
    st_d = st_q; buf_d = buf_q;
    upd = 1'b0; te_set = 1'b0; ae_set = 1'b0;
    case (st_q)
      ST_IDLE: if (run) begin
        if (cnt_q == '0)   te_set = 1'b1;
        else if (misalign) ae_set = 1'b1;
        else               st_d = ST_RD;
      end
      ST_RD: if (mem_ready) begin
        buf_d = mem_rdata & dmask;
        st_d  = ST_WR;
      end
      ST_WR: if (mem_ready) begin
        upd  = 1'b1;
        st_d = ST_IDLE;
        if (cnt_q == CW'(1)) te_set = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (clr) begin
      st_d = ST_IDLE; buf_d = '0; upd = 1'b0;
      if (st_q != ST_IDLE) te_set = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      buf_q <= buf_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = buf_q;
endmodule

// File: rtl/mdma_channel.sv
`timescale 1ns/1ps
module mdma_channel #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              nmi_in,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              irq
);
  logic rst_i_n;
  logic [ADDR_W-1:0] src_w, dst_w, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  cnt_w, cnt_nxt;
  logic en_w, te_w, ie_w, auto_w, me_w, nmi_w, ae_w, clr_w;
  logic [1:0] lg_w, smode_w, dmode_w;
  logic upd_w, te_set_w, ae_set_w, idle_w, busy_w, run_w;

  mdma_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  mdma_regs #(.AW(ADDR_W), .CW(CNT_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
    .upd(upd_w), .src_nxt(src_nxt), .dst_nxt(dst_nxt), .cnt_nxt(cnt_nxt),
    .te_set(te_set_w), .ae_set(ae_set_w), .mv_idle(idle_w),
    .src_q(src_w), .dst_q(dst_w), .cnt_q(cnt_w), .en_q(en_w), .te_q(te_w),
    .ie_q(ie_w), .auto_q(auto_w), .lg(lg_w), .smode_q(smode_w),
    .dmode_q(dmode_w), .me_q(me_w), .nmi_q(nmi_w), .ae_q(ae_w),
    .clr_pulse(clr_w)
  );

  assign busy_w = en_w && !te_w;
  assign run_w  = busy_w && auto_w && me_w && !nmi_w && !ae_w;

  mdma_mover #(.AW(ADDR_W), .CW(CNT_W), .DW(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_i_n), .run(run_w), .clr(clr_w),
    .src_q(src_w), .dst_q(dst_w), .cnt_q(cnt_w), .lg(lg_w),
    .smode(smode_w), .dmode(dmode_w), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .upd(upd_w),
    .src_nxt(src_nxt), .dst_nxt(dst_nxt), .cnt_nxt(cnt_nxt),
    .te_set(te_set_w), .ae_set(ae_set_w), .idle(idle_w)
  );

  assign mem_size = lg_w;
  assign irq      = ie_w && te_w;
endmodule

// File: rtl/mdma_checker.sv
`timescale 1ns/1ps
module mdma_checker #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_size,
  input logic          busy,
  input logic          te,
  input logic          me,
  input logic          nmif,
  input logic          ae,
  input logic [CW-1:0] cnt,
  input logic [AW-1:0] src
);
  logic clr_now;
  assign clr_now = reg_wr && (reg_addr == 3'd5);

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !clr_now) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r6_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready && cnt == CW'(1) && !clr_now) |=> te);

  a_r9_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && busy && !(mem_req && mem_we && mem_ready)) |=> $stable(src));

  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((ae || nmif || !me || !busy) && !mem_req) |=> !mem_req);

  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr & ((AW'(1) << mem_size) - AW'(1))) == '0));

  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cnt != '0));
endmodule

bind mdma_channel mdma_checker #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_size(mem_size), .busy(busy_w), .te(te_w),
  .me(me_w), .nmif(nmi_w), .ae(ae_w), .cnt(cnt_w), .src(src_w)
);

// File: tb/sim_mdma_channel.sv
`timescale 1ns/1ps
module sim_mdma_channel;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_in = 1'b0;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b1;

  mdma_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  assign mem_rdata = pat(mem_addr);

  int n_chk = 0, n_fail = 0, cyc = 0, ready_mode = 0;
  bit done = 0;
  logic [31:0] q_addr[$], q_data[$];
  bit q_we[$], q_last[$];
  bit exp_ie = 0, exp_te = 0;
  bit s1_v = 0, s1_ie = 0, s1_te = 0, s2_v = 0, s2_ie = 0, s2_te = 0, te_s2 = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, compared every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (s2_v) begin exp_ie = s2_ie; exp_te = s2_te; s2_v = 0; end
      if (te_s2) begin exp_te = 1; te_s2 = 0; end
      check("R6 irq", {31'b0, irq}, {31'b0, exp_ie & exp_te});
      case (ready_mode)
        0: mem_ready = 1'b1;
        1: mem_ready = (cyc % 3) != 2;
        default: mem_ready = 1'b0;
      endcase
      cyc++;
      if (mem_req && mem_ready) begin
        if (q_addr.size() == 0) begin
          check("R8 unexpected access", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed; bit ew, el;
          ea = q_addr.pop_front(); ed = q_data.pop_front();
          ew = q_we.pop_front();   el = q_last.pop_front();
          check("R4 address", mem_addr, ea);
          check("R2 direction", {31'b0, mem_we}, {31'b0, ew});
          if (ew) check("R2 data", mem_wdata, ed);
          if (ew && el) te_s2 = 1;
        end
      end
      if (s1_v) begin s2_v = 1; s2_ie = s1_ie; s2_te = s1_te; s1_v = 0; end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 3'd3) begin s1_v = 1; s1_ie = d[2]; s1_te = d[1]; end
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a; #1;
    v = reg_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] ctl(bit en, bit ie, bit [1:0] sz, bit au, bit [1:0] sm, bit [1:0] dm);
    logic [31:0] c = '0;
    c[0] = en; c[2] = ie; c[3] = sz[0]; c[20] = sz[1]; c[10] = au;
    c[15:14] = sm; c[13:12] = dm;
    return c;
  endfunction

  task automatic plan(input logic [31:0] s, input logic [31:0] d, input int n,
                      input int lg, input bit [1:0] sm, input bit [1:0] dm);
    logic [31:0] m, st;
    m = (lg == 0) ? 32'hFF : (lg == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    st = 32'd1 << lg;
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(s); q_data.push_back(0); q_we.push_back(0); q_last.push_back(0);
      q_addr.push_back(d); q_data.push_back(pat(s) & m); q_we.push_back(1); q_last.push_back(i == n - 1);
      if (sm == 2'b01) s = s + st; else if (sm == 2'b10) s = s - st;
      if (dm == 2'b01) d = d + st; else if (dm == 2'b10) d = d - st;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitc(3); #1 rst_n = 1; waitc(4);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); check("R1 reset reg", v, 0); end
    check("R1 req", {31'b0, mem_req}, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2/R3/R5/R6 word copy, both increment
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'd4);
    plan(32'h1000, 32'h2000, 4, 2, 2'b01, 2'b01);
    wr(3'd3, ctl(1, 1, 2'd2, 1, 2'b01, 2'b01));
    waitc(30);
    check("R5 queue drained", q_addr.size(), 0);
    rd(3'd2, v); check("R5 count zero", v, 0);
    rd(3'd0, v); check("R5 src end", v, 32'h1010);
    rd(3'd1, v); check("R5 dst end", v, 32'h2010);
    rd(3'd3, v); check("R6 end flag", {31'b0, v[1]}, 1);
    check("R3 size word", {30'b0, mem_size}, 2);
    check("R6 no access after end", {31'b0, mem_req}, 0);
    wr(3'd3, 32'h0);

    // R4 byte units, fixed source, decrementing destination, stalls
    ready_mode = 1;
    wr(3'd0, 32'h3003); wr(3'd1, 32'h4002); wr(3'd2, 32'd3);
    plan(32'h3003, 32'h4002, 3, 0, 2'b00, 2'b10);
    wr(3'd3, ctl(1, 1, 2'd0, 1, 2'b00, 2'b10));
    waitc(40);
    rd(3'd1, v); check("R4 dst decremented", v, 32'h3FFF);
    rd(3'd0, v); check("R4 src fixed", v, 32'h3003);
    wr(3'd3, 32'h0);
    ready_mode = 0;

    // R3 index 3 falls back to one byte
    wr(3'd0, 32'h5001); wr(3'd1, 32'h6001); wr(3'd2, 32'd2);
    plan(32'h5001, 32'h6001, 2, 0, 2'b01, 2'b01);
    wr(3'd3, ctl(1, 0, 2'd3, 1, 2'b01, 2'b01));
    waitc(20);
    rd(3'd0, v); check("R3 fallback step", v, 32'h5003);
    check("R3 fallback size", {30'b0, mem_size}, 0);
    wr(3'd3, 32'h0);

    // R9 writes ignored while busy
    ready_mode = 2;
    wr(3'd0, 32'h7000); wr(3'd1, 32'h8000); wr(3'd2, 32'd2);
    plan(32'h7000, 32'h8000, 2, 2, 2'b01, 2'b01);
    wr(3'd3, ctl(1, 1, 2'd2, 1, 2'b01, 2'b01));
    waitc(3);
    wr(3'd0, 32'hDEAD_0000); wr(3'd2, 32'd9);
    wr(3'd3, ctl(1, 1, 2'd0, 1, 2'b01, 2'b01));
    rd(3'd0, v); check("R9 src locked", v, 32'h7000);
    rd(3'd2, v); check("R9 cnt locked", v, 2);
    rd(3'd3, v); check("R9 size locked", {31'b0, v[20]}, 1);
    ready_mode = 0;
    waitc(20);
    check("R9 planned accesses", q_addr.size(), 0);
    wr(3'd3, 32'h0);

    // R8 no auto-request, then master enable off
    wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd2, 32'd2);
    wr(3'd3, ctl(1, 0, 2'd2, 0, 2'b01, 2'b01));
    waitc(15);
    check("R8 idle without auto", {31'b0, mem_req}, 0);
    rd(3'd2, v); check("R8 count kept", v, 2);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0);
    plan(32'h100, 32'h200, 2, 2, 2'b01, 2'b01);
    wr(3'd3, ctl(1, 0, 2'd2, 1, 2'b01, 2'b01));
    waitc(10);
    check("R8 idle without master", {31'b0, mem_req}, 0);
    wr(3'd4, 32'h1);
    waitc(15);
    check("R8 runs after enable", q_addr.size(), 0);
    wr(3'd3, 32'h0);

    // R10 misaligned source
    wr(3'd0, 32'h102); wr(3'd1, 32'h200); wr(3'd2, 32'd1);
    wr(3'd3, ctl(1, 1, 2'd2, 1, 2'b01, 2'b01));
    waitc(8);
    rd(3'd4, v); check("R10 error flag", {31'b0, v[2]}, 1);
    rd(3'd3, v); check("R10 enable kept, end clear", v[1:0], 2'b01);
    wr(3'd4, 32'h1);
    waitc(4);
    rd(3'd4, v); check("R11 error again while misaligned", {31'b0, v[2]}, 1);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h5);
    rd(3'd4, v); check("R11 flag sticky on write 1", {31'b0, v[2]}, 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); check("R11 flag cleared", v, 32'h1);

    // R11 event flag mid-transfer
    ready_mode = 2;
    wr(3'd0, 32'h9000); wr(3'd1, 32'hA000); wr(3'd2, 32'd4);
    plan(32'h9000, 32'hA000, 4, 1, 2'b01, 2'b01);
    wr(3'd3, ctl(1, 1, 2'd1, 1, 2'b01, 2'b01));
    waitc(3);
    @(posedge clk); #1 nmi_in = 1; @(posedge clk); #1 nmi_in = 0;
    ready_mode = 0;
    waitc(12);
    rd(3'd2, v); check("R11 partial count", v, 3);
    rd(3'd0, v); check("R11 partial src", v, 32'h9002);
    rd(3'd4, v); check("R11 event flag", {31'b0, v[1]}, 1);
    wr(3'd4, 32'h1);
    waitc(20);
    rd(3'd2, v); check("R11 resumed to end", v, 0);
    rd(3'd0, v); check("R11 final src", v, 32'h9008);
    wr(3'd3, 32'h0);

    // R7 zero count
    wr(3'd2, 32'd0);
    wr(3'd3, ctl(1, 0, 2'd2, 1, 2'b01, 2'b01));
    waitc(4);
    rd(3'd3, v); check("R7 end flag at zero", {31'b0, v[1]}, 1);
    check("R7 no access", {31'b0, mem_req}, 0);
    wr(3'd3, 32'h0);

    // R12 halt keeps pending access, clear drops it
    ready_mode = 2;
    wr(3'd0, 32'hB000); wr(3'd1, 32'hC000); wr(3'd2, 32'd2);
    wr(3'd3, ctl(1, 0, 2'd2, 1, 2'b01, 2'b01));
    waitc(3);
    check("R13 request up", {31'b0, mem_req}, 1);
    wr(3'd3, 32'h0);
    waitc(2);
    check("R12 halt keeps request", {31'b0, mem_req}, 1);
    wr(3'd5, 32'h0);
    #1 check("R12 clear drops request", {31'b0, mem_req}, 0);
    ready_mode = 0;
    waitc(10);
    rd(3'd2, v); check("R12 count untouched", v, 2);
    rd(3'd0, v); check("R12 src untouched", v, 32'hB000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule